// File: doc/BRIEF.md
# Two-Level 16-Bit Lookahead Adder

This block adds two 16-bit operands and a carry-in with no clock and no state. The word is split into four 4-bit slices. Each slice forms per-bit generate (both bits set) and propagate (bits differ) terms and expands every internal carry directly from those terms and the slice carry-in. Each slice also reports a group generate and a group propagate. A second lookahead unit of the same form takes the four group pairs and the word carry-in. From them it produces the carry into every slice and the final carry-out.

The adder is meant as a datapath building block. It sits where a ripple chain would be too slow and a synthesis-chosen adder is not wanted. Besides the sum and carry-out, it exposes the whole-word group generate and propagate, so that a wider lookahead tree can use it as a leaf. It also gives a two's-complement overflow flag for signed use.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + c_in` for every operand pair and carry-in value.
- R2: `c_out` equals bit 16 of `a_i + b_i + c_in`.
- R3: `grp_p_o` is 1 exactly when `a_i[k] != b_i[k]` holds for all 16 bit positions k.
- R4: `grp_g_o` is 1 exactly when `a_i + b_i` (carry-in ignored) exceeds 16'hFFFF.
- R5: `ovf_o` is 1 exactly when the carry into bit 15 differs from `c_out`. This is the case where both operands have the same bit 15 and `sum_o[15]` differs from it.
- R6: The worst-case propagation inputs give the wrapped result. For 16'hFFFF + 16'h0001 with carry-in 0, and for 16'hFFFF + 16'h0000 with carry-in 1, the output is `sum_o` = 0 and `c_out` = 1. When every bit propagates, `c_out` equals `c_in`.
- R7: The carry that the second-level unit hands to each slice equals the carry that the slice below forms internally. The carry-out also equals `grp_g_o | (grp_p_o & c_in)`.
- R8: The outputs are a pure function of the present inputs. They settle without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| c_out | output | 1 | Carry out of bit 15 |
| grp_p_o | output | 1 | Whole-word group propagate |
| grp_g_o | output | 1 | Whole-word group generate |
| ovf_o | output | 1 | Signed overflow |

## Verification
Several directed vectors aim at long carry chains that cross all four slice boundaries: all-ones plus one, all-ones with carry-in, and alternating patterns in which every bit propagates. A wrong term in either lookahead level shows up as a stale zero in a whole slice of the sum, or as a lost carry-out. Signed corners such as 16'h7FFF + 1, 16'h8000 + 16'h8000 and mixed-sign pairs separate the overflow rule from a plain carry-out. An overflow flag tapped from the wrong carry would fire on 16'h8000 + 16'hFFFF's neighbours or stay silent on positive wrap. Random operands with both carry-in values then cover the group generate/propagate outputs against a sum computed in the bench.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned SLICE_W = 4;
    localparam int unsigned N_SLICE = WORD_W / SLICE_W;

    // Generate/propagate pair of one bit or one group
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;

    // Per-bit generate/propagate of one operand bit pair
    function automatic gp_t bit_gp(input logic x, input logic y);
        gp_t r;
        r.gen  = x & y;
        r.prop = x ^ y;
        return r;
    endfunction

endpackage

// File: rtl/cla_lookahead.sv
// Lookahead unit: expands every carry as a two-level sum of products
// of the generate/propagate terms and the incoming carry.
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         cin,
    output logic [N:0]   carry_o,
    output logic         grp_g_o,
    output logic         grp_p_o
);

    always_comb begin
        carry_o[0] = cin;
        for (int i = 0; i < N; i++) begin
            logic acc;
            logic chain;
            chain = cin;
            for (int j = 0; j <= i; j++) chain = chain & prop_i[j];
            acc = chain;
            for (int j = 0; j <= i; j++) begin
                logic prod;
                prod = gen_i[j];
                for (int k = j + 1; k <= i; k++) prod = prod & prop_i[k];
                acc = acc | prod;
            end
            carry_o[i+1] = acc;
        end
    end

    always_comb begin
        logic gacc;
        gacc    = 1'b0;
        grp_p_o = &prop_i;
        for (int j = 0; j < N; j++) begin
            logic prod;
            prod = gen_i[j];
            for (int k = j + 1; k < N; k++) prod = prod & prop_i[k];
            gacc = gacc | prod;
        end
        grp_g_o = gacc;
    end

endmodule

// File: rtl/cla_slice.sv
// One slice: per-bit generate/propagate, local lookahead, sum bits.
module cla_slice
    import cla_pkg::*;
#(
    parameter int unsigned W = SLICE_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin,
    output logic [W-1:0] sum_o,
    output logic         c_msb_o,
    output logic         c_loc_o,
    output gp_t          grp_o
);

    logic [W-1:0] g_bits;
    logic [W-1:0] p_bits;
    logic [W:0]   carries;
    logic         gg;
    logic         gpp;

    for (genvar i = 0; i < W; i++) begin : g_bit
        gp_t gp_b;
        assign gp_b      = bit_gp(a_i[i], b_i[i]);
        assign g_bits[i] = gp_b.gen;
        assign p_bits[i] = gp_b.prop;
        assign sum_o[i]  = gp_b.prop ^ carries[i];
    end

    cla_lookahead #(.N(W)) u_la (
        .gen_i   (g_bits),
        .prop_i  (p_bits),
        .cin     (cin),
        .carry_o (carries),
        .grp_g_o (gg),
        .grp_p_o (gpp)
    );

    assign c_msb_o   = carries[W-1];
    assign c_loc_o   = carries[W];
    assign grp_o.gen  = gg;
    assign grp_o.prop = gpp;

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
    import cla_pkg::*;
(
    input  logic [15:0] a_i,
    input  logic [15:0] b_i,
    input  logic        c_in,
    output logic [15:0] sum_o,
    output logic        c_out,
    output logic        grp_p_o,
    output logic        grp_g_o,
    output logic        ovf_o
);

    localparam int unsigned NS = N_SLICE;
    localparam int unsigned SW = SLICE_W;

    logic [NS:0]   lvl2_carry;
    logic [NS-1:0] sl_g;
    logic [NS-1:0] sl_p;
    logic [NS-1:0] sl_msb;
    logic [NS-1:0] sl_loc;

    for (genvar s = 0; s < NS; s++) begin : g_slice
        gp_t grp;
        cla_slice #(.W(SW)) u_slice (
            .a_i     (a_i[s*SW +: SW]),
            .b_i     (b_i[s*SW +: SW]),
            .cin     (lvl2_carry[s]),
            .sum_o   (sum_o[s*SW +: SW]),
            .c_msb_o (sl_msb[s]),
            .c_loc_o (sl_loc[s]),
            .grp_o   (grp)
        );
        assign sl_g[s] = grp.gen;
        assign sl_p[s] = grp.prop;
    end

    cla_lookahead #(.N(NS)) u_lvl2 (
        .gen_i   (sl_g),
        .prop_i  (sl_p),
        .cin     (c_in),
        .carry_o (lvl2_carry),
        .grp_g_o (grp_g_o),
        .grp_p_o (grp_p_o)
    );

    assign c_out = lvl2_carry[NS];
    assign ovf_o = sl_msb[NS-1] ^ lvl2_carry[NS];

    // Cross-checks between the two lookahead levels and the slice outputs
    always_comb begin
        if (!$isunknown({a_i, b_i, c_in})) begin
            for (int s = 0; s < NS; s++) begin
                AST_SLICE_CARRY: assert (sl_loc[s] == lvl2_carry[s+1]); // R7
            end
            AST_GROUP_CARRY: assert (c_out == (grp_g_o | (grp_p_o & c_in))); // R7
            AST_OVF_SIGN: assert (ovf_o == ((a_i[15] == b_i[15]) && (sum_o[15] != a_i[15]))); // R5
            AST_SUM_LSB: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ c_in)); // R1
            AST_ALL_PROP: assert (!grp_p_o || (c_out == c_in)); // R6
            AST_GEN_EXCL: assert (!(grp_g_o && grp_p_o)); // R3
        end
    end

endmodule

// File: tb/cla_adder16_tb.sv
module cla_adder16_tb;

    logic        clk = 1'b0;
    logic [15:0] a, b;
    logic        cin;
    logic [15:0] sum;
    logic        cout, gp, gg, ovf;
    int          checks = 0;
    int          fails  = 0;
    int          cyc    = 0;

    always #5 clk = ~clk;

    cla_adder16 u_dut (
        .a_i(a), .b_i(b), .c_in(cin),
        .sum_o(sum), .c_out(cout), .grp_p_o(gp), .grp_g_o(gg), .ovf_o(ovf)
    );

    function automatic logic [16:0] ref_add(input logic [15:0] x, input logic [15:0] y, input logic ci);
        return {1'b0, x} + {1'b0, y} + {16'd0, ci};
    endfunction

    function automatic logic ref_ovf(input logic [15:0] x, input logic [15:0] y, input logic [15:0] s);
        return (x[15] == y[15]) && (s[15] != x[15]);
    endfunction

    task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s a=%h b=%h cin=%b act=%h exp=%h", req, a, b, cin, act, exp);
        end
    endtask

    // Drive away from the clock edge, let the logic settle, then compare
    task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic ci);
        logic [16:0] r;
        logic [16:0] r0;
        @(negedge clk);
        a = x; b = y; cin = ci;
        #1;
        r  = ref_add(x, y, ci);
        r0 = ref_add(x, y, 1'b0);
        chk("R1 sum", {1'b0, sum}, {1'b0, r[15:0]});
        chk("R2 cout", {16'd0, cout}, {16'd0, r[16]});
        chk("R3 grp_p", {16'd0, gp}, {16'd0, &(x ^ y)});
        chk("R4 grp_g", {16'd0, gg}, {16'd0, r0[16]});
        chk("R5 ovf", {16'd0, ovf}, {16'd0, ref_ovf(x, y, r[15:0])});
    endtask

    initial begin
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h1234_5678;
        a = '0; b = '0; cin = 1'b0;
        void'($urandom(seed));
        // R8: all-zero inputs give all-zero outputs with no clock edge involved
        #1;
        chk("R8 zero", {sum, cout}, 17'd0);
        chk("R8 flags", {14'd0, gp, gg, ovf}, 17'd0);
        // R6 worst-case carry chains
        apply(16'hFFFF, 16'h0001, 1'b0);
        chk("R6 wrap", {cout, sum}, 17'h10000);
        apply(16'hFFFF, 16'h0000, 1'b1);
        chk("R6 wrap_cin", {cout, sum}, 17'h10000);
        apply(16'hAAAA, 16'h5555, 1'b1);
        chk("R6 allprop", {16'd0, cout}, 17'd1);
        apply(16'hAAAA, 16'h5555, 1'b0);
        chk("R6 allprop0", {16'd0, cout}, 17'd0);
        // R5 signed corners
        apply(16'h7FFF, 16'h0001, 1'b0);
        apply(16'h8000, 16'h8000, 1'b0);
        apply(16'h8000, 16'hFFFF, 1'b0);
        apply(16'h7FFF, 16'h8000, 1'b1);
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        // R7 slice boundary carries
        apply(16'h000F, 16'h0001, 1'b0);
        apply(16'h00FF, 16'h0001, 1'b0);
        apply(16'h0FFF, 16'h0000, 1'b1);
        // R1..R5 random operands
        for (int n = 0; n < 400; n++) begin
            apply(16'($urandom()), 16'($urandom()), 1'($urandom()));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule